// File: doc/BRIEF.md
# Suspend Clock-Stop Sequencer

This block runs the suspend handshake of a processor core and drives the enables of its internal clock gates. An active-low suspend request arrives from outside the chip. The block closes the gates in a fixed order and then answers with an active-low suspend acknowledge. It also raises a flag when the externally supplied system clock may be switched off. The actual gating cells, the PLL and the memory refresh engine sit elsewhere; they consume the enable outputs of this block.

A one-bit mode register chooses between two suspend flavours. The bit is written through a simple write strobe and resets to refresh mode.

- **Refresh suspend:** only the core clock gate closes. The memory-controller and display-controller clocks keep running, so DRAM refresh and the display continue.
- **Full suspend:** the memory/display gate closes as well, after the core gate. Only in this mode may the system clock be stopped.

The mode is captured when a suspend begins. A write made during a suspend applies to the next one.

On release the order is reversed. The acknowledge drops first, then the memory/display gate reopens (full mode only), then the core gate reopens. The spacing between gate steps is the parameter `STEP_CYC`, default 1. The request passes through a `SYNC_STAGES`-deep synchronizer, default 2.

Top module: `susp_clkstop_seq`

## Requirements
- R1: After reset, core_clk_en=1, memdisp_clk_en=1, susp_ack_n=1 and sysclk_stop_ok=0. The mode register resets to 0, so a suspend made without a prior mode write keeps memdisp_clk_en at 1.
- R2: A low level on susp_req_n is seen after SYNC_STAGES clock edges. core_clk_en falls on the following edge. With defaults, a request driven low before edge 1 closes the core gate at edge 3.
- R3: In full mode (mode bit 1), memdisp_clk_en falls STEP_CYC cycles after core_clk_en falls.
- R4: susp_ack_n falls STEP_CYC cycles after the last gate of the selected mode closed. It stays low as long as the synchronized request stays asserted.
- R5: In refresh mode (mode bit 0), memdisp_clk_en stays 1 through the whole entry, suspend and exit.
- R6: sysclk_stop_ok is 1 only while susp_ack_n is 0 and the captured mode is full. In refresh mode it stays 0.
- R7: When the synchronized request deasserts, susp_ack_n rises on the next edge with both gates still in their suspended state. In full mode memdisp_clk_en rises STEP_CYC cycles later. core_clk_en rises STEP_CYC cycles after that (refresh mode: STEP_CYC cycles after susp_ack_n rises).
- R8: A mode write (mode_wr_en=1) during a suspend does not change the gate sequence of that suspend; it applies at the next entry.
- R9: A request withdrawn before the acknowledge still completes the entry. The acknowledge is then given for one cycle before the exit sequence starts.
- R10: core_clk_en is never 1 while memdisp_clk_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| susp_req_n | input | 1 | Suspend request, active low, asynchronous |
| mode_wr_en | input | 1 | Write strobe for the mode register |
| mode_wr_val | input | 1 | Mode value: 0 refresh suspend, 1 full suspend |
| core_clk_en | output | 1 | Enable for the core clock gates |
| memdisp_clk_en | output | 1 | Enable for memory and display controller clock gates |
| susp_ack_n | output | 1 | Suspend acknowledge, active low |
| sysclk_stop_ok | output | 1 | System clock input may be stopped |

## Verification
Two things can fall in the same cycle: a mode-register write and an active suspend sequence that has already captured the other mode. The bench writes the opposite mode while the acknowledge is held in full mode. It then checks that the exit still reopens the memory/display gate as a separate step, and that the next entry follows the new mode. A request pulse short enough to be withdrawn before the acknowledge is also provoked. It is judged by counting, cycle by cycle, how long each gate stays closed and how long the acknowledge stays low.

// File: rtl/susp_seq_pkg.sv
package susp_seq_pkg;

    typedef enum logic {
        MODE_REFRESH = 1'b0,
        MODE_FULL    = 1'b1
    } susp_mode_e;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_CORE_OFF = 3'd1,
        ST_MEM_OFF  = 3'd2,
        ST_ACKED    = 3'd3,
        ST_ACK_DROP = 3'd4,
        ST_MEM_ON   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic core_en;
        logic mem_en;
        logic ack_n;
        logic stop_ok;
    } gate_ctl_s;

    // Gate and handshake levels for a given sequencer state and captured mode.
    function automatic gate_ctl_s decode_gates(seq_state_e st, susp_mode_e md);
        gate_ctl_s g;
        logic      mem_closed;
        mem_closed = (md == MODE_FULL) &&
                     ((st == ST_MEM_OFF) || (st == ST_ACKED) || (st == ST_ACK_DROP));
        g.core_en  = (st == ST_RUN);
        g.mem_en   = !mem_closed;
        g.ack_n    = (st != ST_ACKED);
        g.stop_ok  = (st == ST_ACKED) && (md == MODE_FULL);
        return g;
    endfunction

    // States whose exit waits on the step timer.
    function automatic logic is_timed(seq_state_e st);
        return (st == ST_CORE_OFF) || (st == ST_MEM_OFF) ||
               (st == ST_ACK_DROP) || (st == ST_MEM_ON);
    endfunction

endpackage

// File: rtl/susp_req_sync.sv
module susp_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_async,
    output logic req_act
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= req_n_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign req_act = ~chain[STAGES-1];
endmodule

// File: rtl/susp_mode_reg.sv
module susp_mode_reg
    import susp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_val,
    input  logic       capture,
    output susp_mode_e active_mode
);
    susp_mode_e cfg_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_mode    <= MODE_REFRESH;
            active_mode <= MODE_REFRESH;
        end else begin
            if (wr_en)   cfg_mode    <= susp_mode_e'(wr_val);
            if (capture) active_mode <= cfg_mode;
        end
    end

    // R8: the mode in use changes only at a suspend entry
    a_r8_mode_held: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(active_mode));
endmodule

// File: rtl/susp_step_timer.sv
module susp_step_timer #(
    parameter int STEP_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic done
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (!done)     cnt <= cnt + 1'b1;
    end

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/susp_seq_fsm.sv
module susp_seq_fsm
    import susp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_act,
    input  logic       step_done,
    input  susp_mode_e active_mode,
    output logic       entry,
    output logic       state_change,
    output gate_ctl_s  gates
);
    seq_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (req_act) nxt = ST_CORE_OFF;
            ST_CORE_OFF: if (step_done)
                             nxt = (active_mode == MODE_FULL) ? ST_MEM_OFF : ST_ACKED;
            ST_MEM_OFF:  if (step_done) nxt = ST_ACKED;
            ST_ACKED:    if (!req_act) nxt = ST_ACK_DROP;
            ST_ACK_DROP: if (step_done)
                             nxt = (active_mode == MODE_FULL) ? ST_MEM_ON : ST_RUN;
            ST_MEM_ON:   if (step_done) nxt = ST_RUN;
            default:     nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    assign entry        = (state == ST_RUN) && req_act;
    assign state_change = (nxt != state) && is_timed(nxt);
    assign gates        = decode_gates(state, active_mode);

    // R2: the core gate only closes in answer to a synchronized request
    a_r2_core_on_request: assert property (@(posedge clk) disable iff (rst)
        $fell(gates.core_en) |-> $past(req_act));
    // R4: acknowledge only once the selected gates are closed
    a_r4_ack_after_gates: assert property (@(posedge clk) disable iff (rst)
        $fell(gates.ack_n) |-> (!gates.core_en &&
                                (gates.mem_en == (active_mode == MODE_REFRESH))));
    // R5: refresh mode never closes the memory/display gate
    a_r5_refresh_keeps_mem: assert property (@(posedge clk) disable iff (rst)
        (active_mode == MODE_REFRESH) |-> gates.mem_en);
    // R6: system clock stop only under a full-mode acknowledge
    a_r6_stop_needs_ack: assert property (@(posedge clk) disable iff (rst)
        gates.stop_ok |-> (!gates.ack_n && active_mode == MODE_FULL));
    // R7: acknowledge released before any clock resumes
    a_r7_ack_drops_first: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.ack_n) |-> !gates.core_en);
    // R10: core never runs with memory/display stopped
    a_r10_gate_order: assert property (@(posedge clk) disable iff (rst)
        gates.core_en |-> gates.mem_en);
endmodule

// File: rtl/susp_clkstop_seq.sv
module susp_clkstop_seq
    import susp_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STEP_CYC    = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic susp_req_n,
    input  logic mode_wr_en,
    input  logic mode_wr_val,
    output logic core_clk_en,
    output logic memdisp_clk_en,
    output logic susp_ack_n,
    output logic sysclk_stop_ok
);
    logic       req_act;
    logic       entry;
    logic       restart;
    logic       step_done;
    susp_mode_e active_mode;
    gate_ctl_s  gates;

    susp_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .req_n_async(susp_req_n),
        .req_act    (req_act)
    );

    susp_mode_reg u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (mode_wr_en),
        .wr_val     (mode_wr_val),
        .capture    (entry),
        .active_mode(active_mode)
    );

    susp_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .done   (step_done)
    );

    susp_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_act     (req_act),
        .step_done   (step_done),
        .active_mode (active_mode),
        .entry       (entry),
        .state_change(restart),
        .gates       (gates)
    );

    assign core_clk_en    = gates.core_en;
    assign memdisp_clk_en = gates.mem_en;
    assign susp_ack_n     = gates.ack_n;
    assign sysclk_stop_ok = gates.stop_ok;

    // R6: stop permission implies the acknowledge at the ports
    a_r6_port_stop_ack: assert property (@(posedge clk) disable iff (rst)
        sysclk_stop_ok |-> !susp_ack_n);
endmodule

// File: tb/susp_clkstop_seq_bench.sv
module susp_clkstop_seq_bench;
    localparam time CLK_P = 20ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic susp_req_n = 1'b1;
    logic mode_wr_en = 1'b0;
    logic mode_wr_val = 1'b0;
    logic core_clk_en, memdisp_clk_en, susp_ack_n, sysclk_stop_ok;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    susp_clkstop_seq u_susp_clkstop_seq (
        .clk           (clk),
        .rst           (rst),
        .susp_req_n    (susp_req_n),
        .mode_wr_en    (mode_wr_en),
        .mode_wr_val   (mode_wr_val),
        .core_clk_en   (core_clk_en),
        .memdisp_clk_en(memdisp_clk_en),
        .susp_ack_n    (susp_ack_n),
        .sysclk_stop_ok(sysclk_stop_ok)
    );

    // {req_n, mode_wr_en, mode_wr_val, exp core, exp mem, exp ack_n, exp stop_ok}
    localparam int NV = 20;
    localparam logic [6:0] VECS [0:NV-1] = '{
        7'b111_1110, // 0  R1 write full mode
        7'b000_1110, // 1  R2 request in sync
        7'b000_1110, // 2  R2 request in sync
        7'b000_0110, // 3  R2 core closes
        7'b000_0010, // 4  R3 mem closes
        7'b000_0001, // 5  R4 R6 ack, stop ok
        7'b010_0001, // 6  R8 write refresh while held
        7'b100_0001, // 7  R4 release in sync
        7'b100_0001, // 8  R4 release in sync
        7'b100_0010, // 9  R7 ack drops first
        7'b100_0110, // 10 R7 R8 mem reopens
        7'b100_1110, // 11 R7 core reopens
        7'b000_1110, // 12 R2
        7'b000_1110, // 13 R2
        7'b000_0110, // 14 R5 core closes, mem stays
        7'b000_0100, // 15 R5 R6 ack, no stop ok
        7'b100_0100, // 16 R4
        7'b100_0100, // 17 R4
        7'b100_0110, // 18 R7
        7'b100_1110  // 19 R7
    };

    function automatic string row_tag(int i);
        case (i)
            0:               return "R1";
            1, 2, 3, 12, 13: return "R2";
            4:               return "R3";
            5:               return "R6";
            6, 10:           return "R8";
            14, 15:          return "R5";
            7, 8, 16, 17:    return "R4";
            default:         return "R7";
        endcase
    endfunction

    function automatic logic [3:0] outs();
        return {core_clk_en, memdisp_clk_en, susp_ack_n, sysclk_stop_ok};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        susp_req_n = 1'b1;
        mode_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ack_lo, mem_lo, core_lo;
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1", 32'(outs()), 32'b1110);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            susp_req_n  = VECS[i][6];
            mode_wr_en  = VECS[i][5];
            mode_wr_val = VECS[i][4];
            @(negedge clk);
            mode_wr_en  = 1'b0;
            check(row_tag(i), 32'(outs()), 32'(VECS[i][3:0]));
        end

        // R1: mode resets to refresh; full mode was written before this reset
        do_reset();
        mode_wr_en = 1'b1; mode_wr_val = 1'b1;
        @(negedge clk);
        mode_wr_en = 1'b0;
        do_reset();
        susp_req_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", 32'(outs()), 32'b0100);
        susp_req_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R7", 32'(outs()), 32'b1110);

        // R9: request withdrawn before the acknowledge, full mode
        mode_wr_en = 1'b1; mode_wr_val = 1'b1;
        @(negedge clk);
        mode_wr_en = 1'b0;
        susp_req_n = 1'b0;
        @(negedge clk);
        susp_req_n = 1'b1;
        ack_lo = 0; mem_lo = 0; core_lo = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (!susp_ack_n)     ack_lo++;
            if (!memdisp_clk_en) mem_lo++;
            if (!core_clk_en)    core_lo++;
            if (core_clk_en && !memdisp_clk_en) check("R10", 1, 0);
        end
        check("R9", 32'(ack_lo), 32'd1);
        check("R9", 32'(mem_lo), 32'd3);
        check("R9", 32'(core_lo), 32'd5);
        check("R9", 32'(outs()), 32'b1110);

        // R1: reset during a full suspend returns to the running state
        susp_req_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R6", 32'(outs()), 32'b0001);
        do_reset();
        @(negedge clk);
        check("R1", 32'(outs()), 32'b1110);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule